// File: doc/BRIEF.md
# Timer Input Edge Unit

This block sits on the input side of an 8-bit port and turns pin activity into timer events. Each time the surrounding logic presents a new pin sample, the block merges it into the stored port value. Only the bits that are currently inputs are taken from the sample. The block then looks at which bits actually changed. Pin 7 can drive an 8-bit event counter with a programmable counting edge. Pins 0 to 2 each drive an input-capture detector whose edge sensitivity comes from a 2-bit field.

Counter overflow and captures set sticky flags. Each flag is cleared by a write-one-clear strobe. A capture also gives a one-cycle pulse on that channel's line and a channel code. Any such event raises a one-cycle interrupt-check request, so the interrupt controller can re-examine its pending sources. All outputs are registered and show the effect of an update one clock after it is presented.

Top module: `tic_input_unit`

## Requirements
- R1: On an update, port bits are taken from `pin_in` only where the input mask is 1. The mask is 0x83 when `pin7_is_out` is 0 and 0x03 when it is 1. All other port bits keep their value. Bits 2 to 6 therefore stay at their reset value of 0.
- R2: A bit counts as changed only when the new port value differs from the old one (XOR). Only changed bits may count or capture. A cycle with `upd_valid` low changes nothing except flag clears.
- R3: The counter adds 1 when all of these hold: bit 7 changed, `acc_enable` is 1 and `acc_gated` is 0. It counts on a new level of 1 when `acc_rise` is 1 and on a new level of 0 when `acc_rise` is 0. In every other case the counter holds.
- R4: An increment from 0xFF wraps the counter to 0x00, sets `acc_ovf` and raises `irq_check`.
- R5: Channel i (i = 0, 1, 2) uses `cap_edge_cfg[2i+1:2i]`: 0 disables it, 1 captures rising edges of pin i, 2 captures falling edges and 3 captures both.
- R6: A capture on channel i sets `cap_flag[i]` and pulses `cap_pulse[i]` for one cycle. `cap_id` gives 3 minus the lowest capturing channel index and is 0 when nothing is captured.
- R7: Flags are sticky. A 1 on `clr_ovf` or on `clr_cap[i]` clears the matching flag. If a set and a clear arrive in the same cycle, the set wins.
- R8: All channels that change in one update are evaluated in that same cycle.
- R9: After reset, every output is 0.
- R10: `irq_check` is high for exactly the one cycle after an update that wrapped the counter or captured on any channel. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | New pin sample present this cycle |
| pin_in | input | 8 | External pin sample |
| pin7_is_out | input | 1 | Pin 7 is configured as an output |
| acc_enable | input | 1 | Event counter enable |
| acc_gated | input | 1 | Counter mode: 0 counts edges, 1 suppresses counting |
| acc_rise | input | 1 | Counting edge: 1 rising, 0 falling |
| cap_edge_cfg | input | 6 | Two edge-select bits per capture channel |
| clr_ovf | input | 1 | Write-one-clear for the overflow flag |
| clr_cap | input | 3 | Write-one-clear for the capture flags |
| port_q | output | 8 | Stored port value |
| acc_count | output | 8 | Event counter |
| acc_ovf | output | 1 | Sticky overflow flag |
| cap_flag | output | 3 | Sticky capture flags |
| cap_pulse | output | 3 | One-cycle capture strobes |
| cap_id | output | 2 | Code of the lowest capturing channel (3 − i) |
| irq_check | output | 1 | One-cycle interrupt re-evaluation request |

## Verification
The bound checker watches several invariants on every cycle. The masked port bits and a pin 7 set as output never move. The counter only ever steps by one. A rising overflow flag coincides with a wrap from 0xFF. No capture flag appears without a change on its pin. Every interrupt-check pulse is backed by a set flag. The meaning of each edge-select code, the choice of counting polarity, the set-over-clear priority, the channel code when several channels capture together, and the fact that channel 2 cannot fire through the default mask can only be shown by the bench. Its scenarios compare every output against a behavioural model on each clock.

// File: rtl/tic_pkg.sv
package tic_pkg;

  localparam int PORT_W  = 8;
  localparam int CAP_N   = 3;
  localparam int CNT_W   = 8;
  localparam int CNT_PIN = 7;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  // Merge a sample into the held value through a mask.
  function automatic logic [PORT_W-1:0] merge_pins(
    input logic [PORT_W-1:0] held,
    input logic [PORT_W-1:0] smp,
    input logic [PORT_W-1:0] msk
  );
    return (smp & msk) | (held & ~msk);
  endfunction

  // Does a changed pin at its new level match the edge selection?
  function automatic logic edge_match(input edge_sel_e sel, input logic lvl);
    case (sel)
      EDGE_RISE: return lvl;
      EDGE_FALL: return !lvl;
      EDGE_ANY:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  // Counting qualification for the event counter.
  function automatic logic acc_qualify(
    input logic changed, input logic en, input logic gated,
    input logic rise, input logic lvl
  );
    return changed && en && !gated && (lvl == rise);
  endfunction

endpackage

// File: rtl/tic_port_stage.sv
module tic_port_stage
  import tic_pkg::*;
#(
  parameter logic [PORT_W-1:0] MASK_P7_IN  = 8'h83,
  parameter logic [PORT_W-1:0] MASK_P7_OUT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              pin7_is_out,
  output logic [PORT_W-1:0] port_next,
  output logic [PORT_W-1:0] delta,
  output logic [PORT_W-1:0] port_q
);

  logic [PORT_W-1:0] wr_mask;

  always_comb begin
    wr_mask   = pin7_is_out ? MASK_P7_OUT : MASK_P7_IN;
    port_next = upd_valid ? merge_pins(port_q, pin_in, wr_mask) : port_q;
    delta     = port_next ^ port_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= '0;
    else        port_q <= port_next;
  end

endmodule

// File: rtl/tic_pulse_acc.sv
module tic_pulse_acc
  import tic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_changed,
  input  logic             pin_level,
  input  logic             acc_enable,
  input  logic             acc_gated,
  input  logic             acc_rise,
  input  logic             clr_ovf,
  output logic             acc_wrap,
  output logic [CNT_W-1:0] acc_count,
  output logic             acc_ovf
);

  logic acc_inc;

  always_comb begin
    acc_inc  = acc_qualify(pin_changed, acc_enable, acc_gated, acc_rise, pin_level);
    acc_wrap = acc_inc && (acc_count == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_count <= '0;
      acc_ovf   <= 1'b0;
    end else begin
      if (acc_inc) acc_count <= acc_count + 1'b1;
      if (acc_wrap)     acc_ovf <= 1'b1;
      else if (clr_ovf) acc_ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/tic_edge_unit.sv
module tic_edge_unit
  import tic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAP_N-1:0]   pin_changed,
  input  logic [CAP_N-1:0]   pin_level,
  input  logic [2*CAP_N-1:0] cap_edge_cfg,
  input  logic [CAP_N-1:0]   clr_cap,
  output logic [CAP_N-1:0]   cap_hit,
  output logic [CAP_N-1:0]   cap_flag,
  output logic [CAP_N-1:0]   cap_pulse,
  output logic [1:0]         cap_id
);

  logic [1:0] id_next;

  for (genvar i = 0; i < CAP_N; i++) begin : g_ch
    assign cap_hit[i] = pin_changed[i] &&
                        edge_match(edge_sel_e'(cap_edge_cfg[2*i +: 2]), pin_level[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cap_flag[i] <= 1'b0;
      else if (cap_hit[i])   cap_flag[i] <= 1'b1;
      else if (clr_cap[i])   cap_flag[i] <= 1'b0;
    end
  end

  // Lowest captured index wins the channel code.
  always_comb begin
    id_next = '0;
    for (int i = CAP_N - 1; i >= 0; i--) begin
      if (cap_hit[i]) id_next = 2'(3 - i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pulse <= '0;
      cap_id    <= '0;
    end else begin
      cap_pulse <= cap_hit;
      cap_id    <= id_next;
    end
  end

endmodule

// File: rtl/tic_input_unit.sv
module tic_input_unit
  import tic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_valid,
  input  logic [7:0] pin_in,
  input  logic       pin7_is_out,
  input  logic       acc_enable,
  input  logic       acc_gated,
  input  logic       acc_rise,
  input  logic [5:0] cap_edge_cfg,
  input  logic       clr_ovf,
  input  logic [2:0] clr_cap,
  output logic [7:0] port_q,
  output logic [7:0] acc_count,
  output logic       acc_ovf,
  output logic [2:0] cap_flag,
  output logic [2:0] cap_pulse,
  output logic [1:0] cap_id,
  output logic       irq_check
);

  logic [PORT_W-1:0] port_next;
  logic [PORT_W-1:0] delta;
  logic              acc_wrap;
  logic [CAP_N-1:0]  cap_hit;

  tic_port_stage u_port (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .pin_in(pin_in),
    .pin7_is_out(pin7_is_out), .port_next(port_next), .delta(delta),
    .port_q(port_q)
  );

  tic_pulse_acc u_acc (
    .clk(clk), .rst_n(rst_n), .pin_changed(delta[CNT_PIN]),
    .pin_level(port_next[CNT_PIN]), .acc_enable(acc_enable),
    .acc_gated(acc_gated), .acc_rise(acc_rise), .clr_ovf(clr_ovf),
    .acc_wrap(acc_wrap), .acc_count(acc_count), .acc_ovf(acc_ovf)
  );

  tic_edge_unit u_edge (
    .clk(clk), .rst_n(rst_n), .pin_changed(delta[CAP_N-1:0]),
    .pin_level(port_next[CAP_N-1:0]), .cap_edge_cfg(cap_edge_cfg),
    .clr_cap(clr_cap), .cap_hit(cap_hit), .cap_flag(cap_flag),
    .cap_pulse(cap_pulse), .cap_id(cap_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_check <= 1'b0;
    else        irq_check <= acc_wrap || (|cap_hit);
  end

endmodule

// File: rtl/tic_input_unit_chk.sv
module tic_input_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_valid,
  input logic       pin7_is_out,
  input logic [7:0] port_q,
  input logic [7:0] acc_count,
  input logic       acc_ovf,
  input logic [2:0] cap_flag,
  input logic [2:0] cap_pulse,
  input logic       irq_check
);

  AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(port_q[6:2])); // R1

  AST_PIN7_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pin7_is_out |=> $stable(port_q[7])); // R1

  AST_IDLE_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(port_q)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_count) |-> acc_count == $past(acc_count) + 8'd1); // R3

  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_ovf) |-> (acc_count == 8'h00 && $past(acc_count) == 8'hFF)); // R4

  AST_CAP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    |cap_pulse |-> (cap_pulse & (port_q[2:0] ^ $past(port_q[2:0]))) == cap_pulse); // R2

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag & cap_pulse) == cap_pulse); // R6

  AST_IRQ_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_check |-> (|cap_pulse || $rose(acc_ovf) || (acc_ovf && acc_count == 8'h00))); // R10

endmodule

bind tic_input_unit tic_input_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .pin7_is_out(pin7_is_out),
  .port_q(port_q), .acc_count(acc_count), .acc_ovf(acc_ovf),
  .cap_flag(cap_flag), .cap_pulse(cap_pulse), .irq_check(irq_check)
);

// File: tb/tic_input_unit_tb.sv
module tic_input_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_valid = 1'b0;
  logic [7:0] pin_in = '0;
  logic       pin7_is_out = 1'b0;
  logic       acc_enable = 1'b0;
  logic       acc_gated = 1'b0;
  logic       acc_rise = 1'b1;
  logic [5:0] cap_edge_cfg = '0;
  logic       clr_ovf = 1'b0;
  logic [2:0] clr_cap = '0;
  logic [7:0] port_q;
  logic [7:0] acc_count;
  logic       acc_ovf;
  logic [2:0] cap_flag;
  logic [2:0] cap_pulse;
  logic [1:0] cap_id;
  logic       irq_check;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  string phase = "R9";

  always #10 clk = ~clk;

  tic_input_unit u_dut (.*);

  // Behavioural reference state
  int m_port, m_cnt, m_ovf, m_flag, m_pulse, m_id, m_irq;
  int nport, dl, inc, wrap, msk, fld, lvl, hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_port = 0; m_cnt = 0; m_ovf = 0; m_flag = 0; m_pulse = 0; m_id = 0; m_irq = 0;
    end else begin
      msk   = pin7_is_out ? 'h03 : 'h83;
      nport = upd_valid ? ((pin_in & msk) | (m_port & ~msk & 'hFF)) : m_port;
      dl    = nport ^ m_port;
      inc   = (dl[7] && acc_enable && !acc_gated && (nport[7] == acc_rise)) ? 1 : 0;
      wrap  = (inc == 1 && m_cnt == 255) ? 1 : 0;
      m_cnt = (m_cnt + inc) % 256;
      if (wrap == 1) m_ovf = 1; else if (clr_ovf) m_ovf = 0;
      hit = 0;
      for (int i = 0; i < 3; i++) begin
        fld = (cap_edge_cfg >> (2 * i)) & 3;
        lvl = (nport >> i) & 1;
        if (dl[i] && (fld == 3 || (fld == 1 && lvl == 1) || (fld == 2 && lvl == 0)))
          hit = hit | (1 << i);
      end
      for (int i = 0; i < 3; i++)
        if (!hit[i] && clr_cap[i]) m_flag = m_flag & ~(1 << i);
      m_flag = m_flag | hit;
      m_id = 0;
      for (int i = 2; i >= 0; i--) if (hit[i]) m_id = 3 - i;
      m_pulse = hit;
      m_irq   = (wrap == 1 || hit != 0) ? 1 : 0;
      m_port  = nport;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) actual=0x%0h expected=0x%0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  // Compare every output on the falling edge
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1 port_q", int'(port_q), m_port);
    chk("R3 acc_count", int'(acc_count), m_cnt);
    chk("R4 acc_ovf", int'(acc_ovf), m_ovf);
    chk("R7 cap_flag", int'(cap_flag), m_flag);
    chk("R6 cap_pulse", int'(cap_pulse), m_pulse);
    chk("R6 cap_id", int'(cap_id), m_id);
    chk("R10 irq_check", int'(irq_check), m_irq);
  end

  task automatic upd(input logic [7:0] v);
    @(negedge clk);
    upd_valid = 1'b1; pin_in = v;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R9";
    chk("R9 reset outputs", {port_q, acc_count, acc_ovf, cap_flag, cap_pulse, cap_id, irq_check}, 0);
    rst_n = 1'b1;
    idle(2);

    phase = "R3 rising count";
    acc_enable = 1; acc_rise = 1;
    upd(8'h80); upd(8'h00); upd(8'h80); upd(8'h80);
    phase = "R2 no valid";
    @(negedge clk); pin_in = 8'h03; idle(3);

    phase = "R3 falling count";
    acc_rise = 0;
    upd(8'h00); upd(8'h80); upd(8'h00);
    phase = "R3 gated mode";
    acc_gated = 1; upd(8'h80); upd(8'h00); acc_gated = 0;
    acc_enable = 0; upd(8'h80); upd(8'h00); acc_enable = 1;

    phase = "R4 wrap";
    acc_rise = 1;
    for (int k = 0; k < 260; k++) begin upd(8'h80); upd(8'h00); end
    phase = "R7 clear ovf";
    @(negedge clk); clr_ovf = 1; @(negedge clk); clr_ovf = 0; idle(1);

    phase = "R1 pin7 output";
    pin7_is_out = 1; upd(8'hFF); upd(8'h7C); upd(8'h80); pin7_is_out = 0;
    upd(8'h7C); upd(8'h00);

    phase = "R5 rise only";
    cap_edge_cfg = 6'b00_01_01; upd(8'h01); upd(8'h00); upd(8'h02); upd(8'h00);
    phase = "R5 fall only";
    cap_edge_cfg = 6'b00_10_10; upd(8'h03); upd(8'h02); upd(8'h00);
    phase = "R5 any and off";
    cap_edge_cfg = 6'b00_00_11; upd(8'h03); upd(8'h00);
    phase = "R5 channel 2 masked";
    cap_edge_cfg = 6'b11_00_00; upd(8'h04); upd(8'h00);

    phase = "R7 clear captures";
    @(negedge clk); clr_cap = 3'b111; @(negedge clk); clr_cap = 0; idle(1);

    phase = "R8 simultaneous";
    cap_edge_cfg = 6'b11_11_11; upd(8'h83); upd(8'h00); upd(8'h02);
    phase = "R7 set beats clear";
    @(negedge clk); upd_valid = 1; pin_in = 8'h01; clr_cap = 3'b011; clr_ovf = 1;
    @(negedge clk); upd_valid = 0; clr_cap = 0; clr_ovf = 0;
    idle(3);

    phase = "R9 reset again";
    rst_n = 0; idle(1);
    chk("R9 reset outputs", {port_q, acc_count, acc_ovf, cap_flag, cap_pulse, cap_id, irq_check}, 0);
    rst_n = 1; idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog (all) actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule